// File: doc/BRIEF.md
# Multi-input edge wake-up controller

The controller watches sixteen event lines from pins or peripherals and turns chosen edges on them into latched pending flags. Every channel carries its own enable bit, its own edge-direction bit and a 2-bit field that steers it onto one of four level-sensitive interrupt lines, which a level-triggered interrupt controller consumes. Any channel that is both enabled and pending also raises a single wake request, which the power sequencer uses to leave halt, idle or power-save operation. The wake request does not depend on the steering fields.

Each event line passes through a two-flop synchronizer. A per-channel two-state machine then tracks the synchronized level. In state `LVL_LOW`, a high level takes the transition LOW_TO_HIGH and reports a rising edge. In state `LVL_HIGH`, a low level takes the transition HIGH_TO_LOW and reports a falling edge. In any other case the machine stays in its current state. The edge-direction bit only selects which of the two reports counts, so changing it never creates an event. Software reaches all fields through a small write/read register port. Pending flags are cleared by writing 1, and a new edge in the same cycle as a clear keeps the flag set.

Register addresses are as follows. Address 0 holds the enables and address 1 the edge directions. Address 2 holds the pending flags. Address 3 holds the steering fields of channels 0 to 7, and address 4 those of channels 8 to 15. Addresses 5 to 7 read as zero and ignore writes.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_out` is 0 and `wake_req` is 0.
- R2: On an enabled channel whose direction bit is 0, a low-to-high change of `evt_in[i]` sets pending bit i. The bit can be read at address 2 after the third rising clock edge that follows the change.
- R3: On an enabled channel whose direction bit is 1, a high-to-low change of `evt_in[i]` sets pending bit i with the same three-edge latency.
- R4: A change in the direction opposite to the channel's direction bit does not set pending bit i. A change on a channel whose enable bit (address 0, bit i) is 0 does not set it either.
- R5: A write to address 2 clears each pending bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R6: When a qualifying edge and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R7: `irq_out[k]` is 1 exactly when at least one channel is enabled and pending and has a steering field equal to k. For channel i the field is bits [2*(i%8)+1 : 2*(i%8)] of address 3 (i<8) or address 4 (i>=8).
- R8: `wake_req` is 1 exactly when at least one channel is both enabled and pending, whatever the steering fields hold.
- R9: Changing a direction bit while `evt_in` is steady sets no pending bit.
- R10: Addresses 0, 1, 3 and 4 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 16 | Asynchronous event lines, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| irq_out | output | 4 | Level interrupt lines to the interrupt controller |
| wake_req | output | 1 | Request to leave a low-power mode |

## Verification
A qualifying edge and a software clear can land on the same pending bit in the same cycle. The bench sets a flag first and then raises the event line. It waits exactly two clock edges, so that the synchronized edge and a write-1-to-clear at address 2 are both registered on the third edge. It then judges the result by reading the flag back: the flag must still be set, and a later clear with no edge must remove it. Around this case the bench sweeps every channel over both directions and both enable values, and every channel over all four steering codes, and compares the results with a model computed from the written configuration.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [0:0] {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    localparam int ADDR_EN    = 0;
    localparam int ADDR_POL   = 1;
    localparam int ADDR_PEND  = 2;
    localparam int ROUTE_BASE = 3;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/wk_edge_fsm.sv
module wk_edge_fsm
    import wk_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        lvl_state_t st_q, st_d;
        logic       rise, fall;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= LVL_LOW;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                LVL_LOW:  if (lvl_i[i])  st_d = LVL_HIGH;
                LVL_HIGH: if (!lvl_i[i]) st_d = LVL_LOW;
                default:  st_d = LVL_LOW;
            endcase
        end

        always_comb begin
            rise = 1'b0;
            fall = 1'b0;
            unique case (st_q)
                LVL_LOW:  rise = lvl_i[i];
                LVL_HIGH: fall = !lvl_i[i];
                default:  ;
            endcase
        end

        assign rise_o[i] = rise;
        assign fall_o[i] = fall;
    end
endmodule

// File: rtl/wk_regs.sv
module wk_regs
    import wk_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        rise_i,
    input  logic [NUM_CH-1:0]        fall_i,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NUM_CH-1:0]        wdata_i,
    output logic [NUM_CH-1:0]        rdata_o,
    output logic [NUM_CH-1:0]        en_o,
    output logic [NUM_CH-1:0]        pend_o,
    output logic [NUM_CH*SEL_W-1:0]  route_o,
    output logic [NUM_CH-1:0]        qual_o
);
    localparam int ROUTE_BITS = NUM_CH * SEL_W;

    logic [NUM_CH-1:0]     en_q, pol_q, pend_q;
    logic [ROUTE_BITS-1:0] route_q;
    logic [NUM_CH-1:0]     clr;

    assign qual_o = en_q & ((rise_i & ~pol_q) | (fall_i & pol_q));
    assign clr    = (we_i && addr_i == ADDR_W'(ADDR_PEND)) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            pol_q   <= '0;
            route_q <= '0;
            pend_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | qual_o;
            if (we_i) begin
                if (addr_i == ADDR_W'(ADDR_EN))  en_q  <= wdata_i;
                if (addr_i == ADDR_W'(ADDR_POL)) pol_q <= wdata_i;
                for (int j = 0; j < SEL_W; j++) begin
                    if (addr_i == ADDR_W'(ROUTE_BASE + j))
                        route_q[j*NUM_CH +: NUM_CH] <= wdata_i;
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADDR_EN))   rdata_o = en_q;
        if (addr_i == ADDR_W'(ADDR_POL))  rdata_o = pol_q;
        if (addr_i == ADDR_W'(ADDR_PEND)) rdata_o = pend_q;
        for (int j = 0; j < SEL_W; j++) begin
            if (addr_i == ADDR_W'(ROUTE_BASE + j))
                rdata_o = route_q[j*NUM_CH +: NUM_CH];
        end
    end

    assign en_o    = en_q;
    assign pend_o  = pend_q;
    assign route_o = route_q;
endmodule

// File: rtl/wk_route.sv
module wk_route #(
    parameter int NUM_CH  = 16,
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_CH-1:0]       en_i,
    input  logic [NUM_CH-1:0]       pend_i,
    input  logic [NUM_CH*SEL_W-1:0] route_i,
    output logic [NUM_OUT-1:0]      irq_o,
    output logic                    wake_o
);
    logic [NUM_CH-1:0] active;
    assign active = en_i & pend_i;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic [NUM_CH-1:0] hit;
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign hit[i] = active[i] && (route_i[i*SEL_W +: SEL_W] == SEL_W'(k));
        end
        assign irq_o[k] = |hit;
    end

    assign wake_o = |active;
endmodule

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl #(
    parameter int NUM_CH  = 16,
    parameter int NUM_OUT = 4,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  evt_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_CH-1:0]  reg_wdata,
    output logic [NUM_CH-1:0]  reg_rdata,
    output logic [NUM_OUT-1:0] irq_out,
    output logic               wake_req
);
    localparam int SEL_W = $clog2(NUM_OUT);

    logic [NUM_CH-1:0]       sync_w, rise_w, fall_w;
    logic [NUM_CH-1:0]       en_w, pend_w, qual_w;
    logic [NUM_CH*SEL_W-1:0] route_w;

    wk_sync #(.WIDTH(NUM_CH)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(evt_in), .sync_o(sync_w)
    );

    wk_edge_fsm #(.NUM_CH(NUM_CH)) i_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    wk_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .fall_i(fall_w),
        .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .en_o(en_w), .pend_o(pend_w), .route_o(route_w), .qual_o(qual_w)
    );

    wk_route #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) i_route (
        .en_i(en_w), .pend_i(pend_w), .route_i(route_w), .irq_o(irq_out), .wake_o(wake_req)
    );
endmodule

// File: rtl/wake_edge_ctrl_chk.sv
module wake_edge_ctrl_chk #(
    parameter int NUM_CH  = 16,
    parameter int NUM_OUT = 4,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_CH-1:0]  reg_wdata,
    input logic [NUM_CH-1:0]  en_w,
    input logic [NUM_CH-1:0]  pend_w,
    input logic [NUM_CH-1:0]  qual_w,
    input logic [NUM_CH-1:0]  sync_w,
    input logic [NUM_OUT-1:0] irq_out,
    input logic               wake_req
);
    AST_PEND_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w & ~$past(pend_w) & ~$past(qual_w)) == '0); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(2)) |=> ((pend_w & $past(reg_wdata) & ~$past(qual_w)) == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual_w) |=> ((pend_w & $past(qual_w)) == $past(qual_w))); // R6

    AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> wake_req); // R7

    AST_WAKE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|qual_w) && !reg_we) |=> wake_req); // R8

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual_w) |-> (sync_w != $past(sync_w))); // R9

    AST_WAKE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_w & pend_w) == '0) |-> !wake_req); // R8
endmodule

bind wake_edge_ctrl wake_edge_ctrl_chk #(.NUM_CH(NUM_CH), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_wake_edge_ctrl.sv
`timescale 1ns/1ps
module test_wake_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] evt;
    logic        we;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [3:0]  irq;
    logic        wake;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;

    wake_edge_ctrl i_wake_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq), .wake_req(wake)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // caller is at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        logic [31:0] flat;
        rst_n = 1'b0; evt = '0; we = 1'b0; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), {16'h0, d}, 32'h0);
        end
        chk("R1 irq after reset", {28'h0, irq}, 32'h0);
        chk("R1 wake after reset", {31'h0, wake}, 32'h0);

        // R10 readback
        wr(3'd0, 16'hA5C3); wr(3'd1, 16'h5A3C); wr(3'd3, 16'h1234); wr(3'd4, 16'hFEDC);
        wr(3'd6, 16'hFFFF);
        rd(3'd0, d); chk("R10 enable readback", {16'h0, d}, 32'hA5C3);
        rd(3'd1, d); chk("R10 polarity readback", {16'h0, d}, 32'h5A3C);
        rd(3'd3, d); chk("R10 route low readback", {16'h0, d}, 32'h1234);
        rd(3'd4, d); chk("R10 route high readback", {16'h0, d}, 32'hFEDC);
        rd(3'd6, d); chk("R10 unused address reads 0", {16'h0, d}, 32'h0);
        wr(3'd3, 16'h0); wr(3'd4, 16'h0);

        // R2 R3 R4 sweep: every channel, both directions, enable on/off
        for (int ch = 0; ch < 16; ch++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int en = 0; en < 2; en++) begin
                    wr(3'd0, en ? 16'(1 << ch) : 16'h0);
                    wr(3'd1, pol ? 16'(1 << ch) : 16'h0);
                    evt[ch] = 1'b1; settle();
                    rd(3'd2, d);
                    chk($sformatf("R2 R4 rise ch%0d pol%0d en%0d", ch, pol, en), {16'h0, d},
                        (en == 1 && pol == 0) ? 32'(1 << ch) : 32'h0);
                    wr(3'd2, 16'hFFFF);
                    evt[ch] = 1'b0; settle();
                    rd(3'd2, d);
                    chk($sformatf("R3 R4 fall ch%0d pol%0d en%0d", ch, pol, en), {16'h0, d},
                        (en == 1 && pol == 1) ? 32'(1 << ch) : 32'h0);
                    wr(3'd2, 16'hFFFF);
                end
            end
        end

        // R5 partial clear, zero write leaves bits
        wr(3'd0, 16'hFFFF); wr(3'd1, 16'h0);
        evt = 16'hFFFF; settle();
        rd(3'd2, d); chk("R2 all channels rise", {16'h0, d}, 32'hFFFF);
        wr(3'd2, 16'h0);
        rd(3'd2, d); chk("R5 zero write keeps flags", {16'h0, d}, 32'hFFFF);
        wr(3'd2, 16'h00FF);
        rd(3'd2, d); chk("R5 partial clear", {16'h0, d}, 32'hFF00);
        wr(3'd2, 16'hFFFF);
        rd(3'd2, d); chk("R5 full clear", {16'h0, d}, 32'h0);

        // R9 direction change with steady inputs (all high)
        wr(3'd1, 16'hFFFF); settle();
        rd(3'd2, d); chk("R9 pol 0->1 steady high", {16'h0, d}, 32'h0);
        wr(3'd1, 16'h0); settle();
        rd(3'd2, d); chk("R9 pol 1->0 steady high", {16'h0, d}, 32'h0);
        evt = '0; settle();
        rd(3'd2, d); chk("R4 falls ignored at pol 0", {16'h0, d}, 32'h0);
        wr(3'd1, 16'hFFFF); settle();
        rd(3'd2, d); chk("R9 pol 0->1 steady low", {16'h0, d}, 32'h0);
        wr(3'd1, 16'h0);

        // R7 R8 routing sweep
        for (int ch = 0; ch < 16; ch++) begin
            for (int r = 0; r < 4; r++) begin
                flat = 32'(r) << (2 * ch);
                wr(3'd3, flat[15:0]); wr(3'd4, flat[31:16]);
                wr(3'd0, 16'(1 << ch));
                evt[ch] = 1'b1; settle();
                chk($sformatf("R7 ch%0d route%0d irq", ch, r), {28'h0, irq}, 32'(1 << r));
                chk($sformatf("R8 ch%0d route%0d wake", ch, r), {31'h0, wake}, 32'h1);
                wr(3'd0, 16'h0);
                chk($sformatf("R7 ch%0d disabled irq", ch), {28'h0, irq}, 32'h0);
                chk($sformatf("R8 ch%0d disabled wake", ch), {31'h0, wake}, 32'h0);
                wr(3'd2, 16'hFFFF);
                evt[ch] = 1'b0; settle();
            end
        end

        // R7 many channels: ch i -> output i%4, then all to output 2
        wr(3'd3, 16'hE4E4); wr(3'd4, 16'hE4E4); wr(3'd0, 16'hFFFF);
        evt = 16'h0011; settle();
        chk("R7 ch0 ch4 both on output0", {28'h0, irq}, 32'h1);
        evt = 16'hFFFF; settle();
        chk("R7 all outputs", {28'h0, irq}, 32'hF);
        wr(3'd3, 16'hAAAA); wr(3'd4, 16'hAAAA);
        chk("R7 all to output2", {28'h0, irq}, 32'h4);
        chk("R8 wake independent of routing", {31'h0, wake}, 32'h1);
        wr(3'd2, 16'hFFFF);
        chk("R8 wake low after clear", {31'h0, wake}, 32'h0);
        evt = '0; settle();

        // R6 set and clear in the same cycle on channel 5
        wr(3'd3, 16'h0); wr(3'd4, 16'h0);
        wr(3'd0, 16'h0020); wr(3'd1, 16'h0);
        evt[5] = 1'b1; settle();
        rd(3'd2, d); chk("R2 ch5 pending before collision", {16'h0, d}, 32'h20);
        evt[5] = 1'b0; settle();
        evt[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        we = 1'b1; addr = 3'd2; wdata = 16'h0020;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        rd(3'd2, d); chk("R6 edge beats clear", {16'h0, d}, 32'h20);
        wr(3'd2, 16'h0020);
        rd(3'd2, d); chk("R5 clear without edge", {16'h0, d}, 32'h0);
        evt[5] = 1'b0; settle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule